// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio. It models a dual-modulus prescaler that divides by either 8 or 9, and two counters that control it. The swallow counter sets how many prescaler periods in each output cycle use divide-by-9. The main counter sets how many prescaler periods make up one output cycle. The total ratio is eight times the main count plus the swallow count.

The 14-bit ratio word sits on parallel pins and is not latched. Its low three bits give the swallow count A and its upper eleven bits give the main count M. The numeric value of the whole word is therefore the division ratio itself.

The block drives two outputs. The modulus-select line shows which modulus the prescaler uses. The divided output emits one fixed-width pulse per output cycle. A synchronous reset clears all state. After reset the block loads the word and starts a fresh output cycle.

Top module: `swallow_divider`

## Requirements
- R1: With word `ratio` = 8·M + A (M = bits 13..3, A = bits 2..0), the rising edges of `div_out` lie exactly `ratio` input clock cycles apart, for every value from 56 to 16383.
- R2: In each output period, `mod_ctl` is high (divide-by-9) for exactly 9·A input clock cycles and low for all others. It goes high on the cycle that `div_out` rises whenever A is non-zero.
- R3: When A = 0, `mod_ctl` stays low for the whole output period.
- R4: Each `div_out` pulse stays high for exactly 8 input clock cycles.
- R5: While `rst` is high, and on the cycle after it, `div_out` and `mod_ctl` are low. After `rst` falls, the first `div_out` rise is sampled `ratio` + 1 clock edges after release: one load edge, then one full ratio period.
- R6: The ratio word is read only when the counters reload at the end of an output cycle. A change in the middle of a cycle leaves that cycle's length unchanged, and the new ratio governs the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | 14 | Division ratio word: A in bits 2..0, M in bits 13..3 |
| mod_ctl | output | 1 | Modulus select: 1 = divide by 9, 0 = divide by 8 |
| div_out | output | 1 | Divided output, one 8-cycle pulse per output period |

## Verification
The bench sweeps every ratio from 56 to 127 and adds 1000 and 16383. This covers M = A at 63, A = 0 at 56 and 64, and the all-ones word.

A design that treats the end of the swallow count as the end of the cycle would give a period off by one prescaler period. A design with an off-by-one on the modulus boundary would give a mod-high count different from 9·A. A design that widened the pulse to the last prescaler period would give 9-cycle pulses at 63.

The latency from reset is measured directly, and a wrong load cycle shows up as a shift of one edge. A mid-cycle ratio change checks that the reload is the only point where the word is sampled. A design that reads the word continuously would shorten or lengthen the current period.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  // Prescaler modulus selection
  typedef enum logic {
    MOD_BASE  = 1'b0,  // divide by base modulus
    MOD_PLUS1 = 1'b1   // divide by base modulus + 1
  } mod_sel_e;

  localparam int unsigned PRE_BASE_DEF = 8;
  localparam int unsigned SWAL_W_DEF   = 3;
  localparam int unsigned MAIN_W_DEF   = 11;
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler #(
  parameter int unsigned BASE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic plus_one,
  output logic wrap
);
  localparam int unsigned CW = $clog2(BASE + 1);

  logic [CW-1:0] phase_q;
  logic [CW-1:0] last_phase;

  always_comb begin
    last_phase = plus_one ? CW'(BASE) : CW'(BASE - 1);
    wrap       = !hold && (phase_q == last_phase);
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      phase_q <= '0;
    end else if (wrap) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl #(
  parameter int unsigned SWAL_W = 3,
  parameter int unsigned MAIN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SWAL_W-1:0] load_a,
  input  logic [MAIN_W-1:0] load_m,
  input  logic              wrap,
  output logic              loaded,
  output logic              plus_one,
  output logic              cycle_end
);
  import swallow_pkg::*;

  logic [SWAL_W-1:0] a_left_q;
  logic [MAIN_W-1:0] m_left_q;
  logic              loaded_q;
  mod_sel_e          mode_q;

  assign loaded    = loaded_q;
  assign plus_one  = (mode_q == MOD_PLUS1);
  assign cycle_end = wrap && (m_left_q == MAIN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_left_q <= '0;
      m_left_q <= '0;
      loaded_q <= 1'b0;
      mode_q   <= MOD_BASE;
    end else if (!loaded_q || cycle_end) begin
      loaded_q <= 1'b1;
      m_left_q <= load_m;
      a_left_q <= load_a;
      mode_q   <= (load_a != '0) ? MOD_PLUS1 : MOD_BASE;
    end else if (wrap) begin
      m_left_q <= m_left_q - MAIN_W'(1);
      if (mode_q == MOD_PLUS1) begin
        a_left_q <= a_left_q - SWAL_W'(1);
        mode_q   <= (a_left_q != SWAL_W'(1)) ? MOD_PLUS1 : MOD_BASE;
      end
    end
  end
endmodule

// File: rtl/out_stretch.sv
module out_stretch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  generate
    if (WIDTH <= 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= fire;
      end
    end else begin : g_multi
      logic [CW-1:0] left_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pulse  <= 1'b0;
          left_q <= '0;
        end else if (fire) begin
          pulse  <= 1'b1;
          left_q <= CW'(WIDTH - 1);
        end else if (pulse) begin
          if (left_q == '0) pulse <= 1'b0;
          else              left_q <= left_q - CW'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned PRE_BASE = swallow_pkg::PRE_BASE_DEF,
  parameter int unsigned SWAL_W   = swallow_pkg::SWAL_W_DEF,
  parameter int unsigned MAIN_W   = swallow_pkg::MAIN_W_DEF,
  localparam int unsigned RW      = SWAL_W + MAIN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ratio,
  output logic          mod_ctl,
  output logic          div_out
);
  logic wrap;
  logic loaded;
  logic plus_one;
  logic cycle_end;

  dm_prescaler #(.BASE(PRE_BASE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .hold     (!loaded),
    .plus_one (plus_one),
    .wrap     (wrap)
  );

  swallow_ctrl #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .load_a    (ratio[SWAL_W-1:0]),
    .load_m    (ratio[RW-1:SWAL_W]),
    .wrap      (wrap),
    .loaded    (loaded),
    .plus_one  (plus_one),
    .cycle_end (cycle_end)
  );

  out_stretch #(.WIDTH(PRE_BASE)) u_out (
    .clk   (clk),
    .rst   (rst),
    .fire  (cycle_end),
    .pulse (div_out)
  );

  assign mod_ctl = plus_one;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int unsigned PRE_BASE = 8,
  parameter int unsigned SWAL_W   = 3,
  parameter int unsigned MAIN_W   = 11,
  localparam int unsigned RW      = SWAL_W + MAIN_W
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] ratio,
  input logic          mod_ctl,
  input logic          div_out
);
  logic          d_q;
  logic          seen_q;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] exp_q;
  logic [RW+1:0] per_cnt;
  logic [RW+1:0] mod_cnt;
  logic [RW+1:0] hi_cnt;
  logic          rise;

  assign rise = div_out && !d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q     <= 1'b0;
      seen_q  <= 1'b0;
      ratio_q <= '0;
      exp_q   <= '0;
      per_cnt <= '0;
      mod_cnt <= '0;
      hi_cnt  <= '0;
    end else begin
      d_q     <= div_out;
      ratio_q <= ratio;
      hi_cnt  <= div_out ? hi_cnt + 1'b1 : '0;
      if (rise) begin
        seen_q  <= 1'b1;
        exp_q   <= ratio_q;
        per_cnt <= (RW+2)'(1);
        mod_cnt <= (RW+2)'(mod_ctl);
      end else begin
        per_cnt <= per_cnt + 1'b1;
        mod_cnt <= mod_cnt + (RW+2)'(mod_ctl);
      end
    end
  end

  // R1 / R6: period equals the word sampled at the reload
  p_period_r1: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_q) |-> (per_cnt == (RW+2)'(exp_q)));

  // R2 / R3: divide-by-9 cycles per period
  p_mod_cycles_r2: assert property (@(posedge clk) disable iff (rst)
    (rise && seen_q) |-> (mod_cnt == (RW+2)'(9 * exp_q[SWAL_W-1:0])));

  // R4: pulse width
  p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
    (!div_out && d_q) |-> (hi_cnt == (RW+2)'(PRE_BASE)));

  // R5: outputs quiet after a reset edge
  p_reset_quiet_r5: assert property (@(posedge clk)
    rst |=> (!div_out && !mod_ctl));
endmodule

bind swallow_divider swallow_divider_chk #(
  .PRE_BASE (PRE_BASE),
  .SWAL_W   (SWAL_W),
  .MAIN_W   (MAIN_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ratio   (ratio),
  .mod_ctl (mod_ctl),
  .div_out (div_out)
);

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ratio = 14'd56;
  logic        mod_ctl;
  logic        div_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  swallow_divider u0 (
    .clk     (clk),
    .rst     (rst),
    .ratio   (ratio),
    .mod_ctl (mod_ctl),
    .div_out (div_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual cycles %0d, expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (ratio %0d)", req, act, exp, ratio);
    end
  endtask

  // Reset, then return at the negedge where div_out is first seen high.
  task automatic reset_and_first(input int r);
    rst = 1'b1;
    ratio = r[13:0];
    repeat (3) @(negedge clk);
    check("R5 reset div_out", int'(div_out), 0);
    check("R5 reset mod_ctl", int'(mod_ctl), 0);
    rst = 1'b0;
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!div_out && n < 20000);
      check("R5 first pulse latency", n, r + 1);
    end
  endtask

  // From a rise sample, run to the next rise sample.
  task automatic one_period(output int len, output int mc, output int hw);
    logic p;
    len = 0; mc = 0; hw = 0;
    do begin
      p = div_out;
      mc += int'(mod_ctl);
      hw += int'(div_out);
      @(negedge clk);
      len++;
    end while (!(div_out && !p) && len < 20000);
  endtask

  task automatic run_ratio(input int r);
    int len, mc, hw;
    reset_and_first(r);
    if (r[2:0] != 0) check("R2 mod_ctl at cycle start", int'(mod_ctl), 1);
    for (int k = 0; k < 2; k++) begin
      one_period(len, mc, hw);
      check("R1 period", len, r);
      if (r[2:0] == 0) check("R3 mod_ctl idle for A=0", mc, 0);
      else             check("R2 divide-by-9 cycles", mc, 9 * r[2:0]);
      check("R4 pulse width", hw, 8);
    end
  endtask

  initial begin
    int len, mc, hw;
    for (int r = 56; r <= 127; r++) run_ratio(r);
    run_ratio(1000);
    run_ratio(16383);

    // R6: change the word mid-cycle
    reset_and_first(200);
    repeat (20) @(negedge clk);
    ratio = 14'd77;
    one_period(len, mc, hw);
    check("R6 current period keeps old ratio", len + 20, 200);
    one_period(len, mc, hw);
    check("R6 next period uses new ratio", len, 77);
    check("R6 new mod cycles", mc, 9 * 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule